// File: doc/BRIEF.md
# I2C Pin Multiplexer with Recovery GPIO

This block sits between an I2C controller's open-drain clock and data drivers and the two bus pads. In its normal mode the controller's pull-down enables reach the pads unchanged. A single mode bit hands both pads to a small GPIO unit. Firmware can then toggle the clock line by hand to free a target that is holding the data line low, and afterwards return the pads to the controller.

The GPIO unit has three parts. A direction register decides which pads it drives. An output-level register can be written whole, or changed one bit at a time through write-one-to-set and write-one-to-clear addresses. An input register shows both pad levels through a two-flop synchronizer. Both pads are open-drain, so a high output releases the pad and a low output pulls it down. The controller always sees the raw pad levels. Access is through a 16-bit register port whose writes take effect at a rising clock edge and whose reads are combinational.

The mode is held by a two-state machine. `MODE_I2C` is the state after reset. The transition `TO_GPIO` is taken on a write of 1 to bit 0 of the mode register. The transition `TO_I2C` is taken on a write of 0 to that bit. Any other write leaves the state where it is.

Top module: `i2c_pin_mux`

## Requirements
- R1: After reset the block is in `MODE_I2C`. The mode register reads 0, the direction register reads 0 and the output-level register reads 0x0003 (both pads released).
- R2: In `MODE_I2C` each pad pull-down enable equals the controller's enable for that pad, in the same cycle.
- R3: The controller's level inputs always equal the raw pad levels, in both modes, with no delay.
- R4: The mode register is at offset 0x48. Writing bit 0 = 1 moves the block to `MODE_GPIO` for both pads, and writing bit 0 = 0 returns it to `MODE_I2C`. The register reads back the mode in bit 0 and zeros in every other bit.
- R5: In `MODE_GPIO`, a pad is pulled down exactly when its direction bit is 1 (output) and its output-level bit is 0. In every GPIO register, bit 0 is the clock pad and bit 1 is the data pad. The direction register is at offset 0x4C.
- R6: A write to the output-level register at 0x54 replaces both level bits. The register reads back the current output state.
- R7: A write to 0x58 sets each output-level bit whose write bit is 1, and leaves bits written 0 unchanged.
- R8: A write to 0x5C clears each output-level bit whose write bit is 1, and leaves bits written 0 unchanged.
- R9: The input register at 0x50 shows the pad levels through two flops. A level change that is present before rising edge k reads back after edge k+1 and not after edge k. This holds in both modes.
- R10: The following all read as zero: offsets 0x58 and 0x5C, and any offset that is not mapped. Writes to 0x50 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ctl_scl_oe | input | 1 | Controller clock pull-down enable |
| ctl_sda_oe | input | 1 | Controller data pull-down enable |
| ctl_scl_in | output | 1 | Clock pad level to the controller |
| ctl_sda_in | output | 1 | Data pad level to the controller |
| pad_scl_in | input | 1 | Clock pad level |
| pad_sda_in | input | 1 | Data pad level |
| pad_scl_oe | output | 1 | Clock pad pull-down enable |
| pad_sda_oe | output | 1 | Data pad pull-down enable |

## Verification
The bench mixes random writes of the mode, direction, level, set and clear registers, and after each write compares the pad enables and the readbacks with a model. This catches a design that treats zero bits in a set or clear write as active: such a design would wipe out the other pad's level. It also catches a design that drives a pad whose direction is input, or one that keeps obeying the controller while in GPIO mode. Directed cases time the synchronizer edge by edge, so one flop too few or too many shows up as a one-cycle error. They also check that writes to the input register or to unmapped offsets leave every register unchanged. Finally they confirm that the mode bit moves both pads together, and that leaving GPIO mode hands the pads straight back to the controller.

// File: rtl/i2cmux_pkg.sv
package i2cmux_pkg;
    localparam int unsigned NPINS = 2;
    localparam logic [7:0] OFS_MODE = 8'h48;
    localparam logic [7:0] OFS_DIR  = 8'h4C;
    localparam logic [7:0] OFS_DIN  = 8'h50;
    localparam logic [7:0] OFS_DOUT = 8'h54;
    localparam logic [7:0] OFS_SET  = 8'h58;
    localparam logic [7:0] OFS_CLR  = 8'h5C;

    typedef enum logic {
        MODE_I2C  = 1'b0,
        MODE_GPIO = 1'b1
    } mux_mode_e;
endpackage

// File: rtl/i2cmux_sync.sv
module i2cmux_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b1;
                stable_q <= 1'b1;
            end else begin
                meta_q   <= async_in[i];
                stable_q <= meta_q;
            end
        end
        assign sync_out[i] = stable_q;
    end
endmodule

// File: rtl/i2cmux_regs.sv
module i2cmux_regs
    import i2cmux_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16,
    parameter int unsigned NP = NPINS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [NP-1:0] din_sync,
    output logic          gpio_mode,
    output logic [NP-1:0] dir_q,
    output logic [NP-1:0] dout_q
);
    localparam int unsigned PADW = DW - NP;

    mux_mode_e     state_q, state_d;
    logic          wr_mode, wr_dir, wr_dout, wr_set, wr_clr;
    logic [NP-1:0] wbits;
    logic [NP-1:0] dout_d;
    logic          unused_wdata;

    assign wbits        = wdata[NP-1:0];
    assign unused_wdata = ^wdata[DW-1:NP];
    assign wr_mode = wr_en && (addr == AW'(OFS_MODE));
    assign wr_dir  = wr_en && (addr == AW'(OFS_DIR));
    assign wr_dout = wr_en && (addr == AW'(OFS_DOUT));
    assign wr_set  = wr_en && (addr == AW'(OFS_SET));
    assign wr_clr  = wr_en && (addr == AW'(OFS_CLR));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_I2C;
        else        state_q <= state_d;
    end

    // Transitions TO_GPIO / TO_I2C
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_I2C:  if (wr_mode && wdata[0])  state_d = MODE_GPIO;
            MODE_GPIO: if (wr_mode && !wdata[0]) state_d = MODE_I2C;
            default:   state_d = MODE_I2C;
        endcase
    end

    // State outputs
    always_comb begin
        unique case (state_q)
            MODE_GPIO: gpio_mode = 1'b1;
            default:   gpio_mode = 1'b0;
        endcase
    end

    always_comb begin
        dout_d = dout_q;
        if (wr_dout)     dout_d = wbits;
        else if (wr_set) dout_d = dout_q | wbits;
        else if (wr_clr) dout_d = dout_q & ~wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '1;
        end else begin
            if (wr_dir) dir_q <= wbits;
            dout_q <= dout_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_MODE))      rdata = {{(DW-1){1'b0}}, gpio_mode};
        else if (addr == AW'(OFS_DIR))  rdata = {{PADW{1'b0}}, dir_q};
        else if (addr == AW'(OFS_DIN))  rdata = {{PADW{1'b0}}, din_sync};
        else if (addr == AW'(OFS_DOUT)) rdata = {{PADW{1'b0}}, dout_q};
    end
endmodule

// File: rtl/i2cmux_pinsel.sv
module i2cmux_pinsel #(
    parameter int unsigned NP = 2
) (
    input  logic          gpio_mode,
    input  logic [NP-1:0] dir,
    input  logic [NP-1:0] dout,
    input  logic [NP-1:0] ctl_oe,
    output logic [NP-1:0] pad_oe
);
    for (genvar i = 0; i < NP; i++) begin : g_pin
        assign pad_oe[i] = gpio_mode ? (dir[i] & ~dout[i]) : ctl_oe[i];
    end
endmodule

// File: rtl/i2c_pin_mux.sv
module i2c_pin_mux
    import i2cmux_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ctl_scl_oe,
    input  logic          ctl_sda_oe,
    output logic          ctl_scl_in,
    output logic          ctl_sda_in,
    input  logic          pad_scl_in,
    input  logic          pad_sda_in,
    output logic          pad_scl_oe,
    output logic          pad_sda_oe
);
    logic [NPINS-1:0] pad_lvl, din_sync, dir_q, dout_q, ctl_oe, pad_oe;
    logic             gpio_mode;

    assign pad_lvl = {pad_sda_in, pad_scl_in};
    assign ctl_oe  = {ctl_sda_oe, ctl_scl_oe};
    assign ctl_scl_in = pad_scl_in;
    assign ctl_sda_in = pad_sda_in;
    assign pad_scl_oe = pad_oe[0];
    assign pad_sda_oe = pad_oe[1];

    i2cmux_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_lvl), .sync_out(din_sync)
    );

    i2cmux_regs #(.AW(AW), .DW(DW), .NP(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .din_sync(din_sync),
        .gpio_mode(gpio_mode), .dir_q(dir_q), .dout_q(dout_q)
    );

    i2cmux_pinsel #(.NP(NPINS)) u_pins (
        .gpio_mode(gpio_mode), .dir(dir_q), .dout(dout_q),
        .ctl_oe(ctl_oe), .pad_oe(pad_oe)
    );
endmodule

// File: rtl/i2c_pin_mux_chk.sv
module i2c_pin_mux_chk
    import i2cmux_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          ctl_scl_oe,
    input logic          ctl_sda_oe,
    input logic          ctl_scl_in,
    input logic          ctl_sda_in,
    input logic          pad_scl_in,
    input logic          pad_sda_in,
    input logic          pad_scl_oe,
    input logic          pad_sda_oe,
    input logic          gpio_mode,
    input logic [1:0]    dir_q,
    input logic [1:0]    din_sync
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r2_i2c_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_mode |-> (pad_scl_oe == ctl_scl_oe && pad_sda_oe == ctl_sda_oe));

    a_r3_level_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_scl_in == pad_scl_in) && (ctl_sda_in == pad_sda_in));

    a_r7_set_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_SET) && reg_wdata[0] && gpio_mode) |=> !pad_scl_oe);

    a_r8_clear_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(OFS_CLR) && reg_wdata[1] && gpio_mode && dir_q[1])
        |=> pad_sda_oe);

    a_r9_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (din_sync == $past({pad_sda_in, pad_scl_in}, 2)));
endmodule

bind i2c_pin_mux i2c_pin_mux_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_i2c_pin_mux.sv
module sim_i2c_pin_mux;
    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic ctl_scl_oe = 0, ctl_sda_oe = 0, ctl_scl_in, ctl_sda_in;
    logic pad_scl_in = 1, pad_sda_in = 1, pad_scl_oe, pad_sda_oe;
    int   n_run = 0, n_fail = 0;

    logic       m_mode;
    logic [1:0] m_dir, m_dout;

    always #10 clk = ~clk;

    i2c_pin_mux u0 (.*);

    function automatic logic [1:0] exp_oe(input logic md, input logic [1:0] d,
                                          input logic [1:0] o, input logic [1:0] c);
        return md ? (d & ~o) : c;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    initial begin
        #2000000;
        n_fail++; n_run++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_mode = 0; m_dir = 0; m_dout = 2'b11;
        rd(8'h48, v); chk("R1 mode", v, 16'h0);
        rd(8'h4C, v); chk("R1 dir", v, 16'h0);
        rd(8'h54, v); chk("R1 dout", v, 16'h3);

        // R3 feedback and R2 passthrough
        pad_scl_in = 0; ctl_sda_oe = 1; #1;
        chk("R3 feedback", {ctl_sda_in, ctl_scl_in}, 2'b10);
        chk("R2 passthru", {pad_sda_oe, pad_scl_oe}, 2'b10);
        pad_scl_in = 1; ctl_sda_oe = 0;

        // R9 sync timing
        @(negedge clk); pad_sda_in = 0;
        @(negedge clk); rd(8'h50, v); chk("R9 one edge", v, 16'h3);
        @(negedge clk); rd(8'h50, v); chk("R9 two edges", v, 16'h1);
        pad_sda_in = 1;

        // R4 mode with upper bits
        wr(8'h48, 16'hFFFF); m_mode = 1;
        rd(8'h48, v); chk("R4 readback", v, 16'h1);
        // R10 ignored writes
        wr(8'h50, 16'h0000); wr(8'h44, 16'h0000); wr(8'h60, 16'h0000);
        rd(8'h54, v); chk("R10 dout kept", v, 16'h3);
        rd(8'h4C, v); chk("R10 dir kept", v, 16'h0);
        rd(8'h48, v); chk("R10 mode kept", v, 16'h1);
        rd(8'h58, v); chk("R10 set reads 0", v, 16'h0);
        rd(8'h5C, v); chk("R10 clr reads 0", v, 16'h0);
        rd(8'h40, v); chk("R10 unmapped 0", v, 16'h0);

        // R5 directed: recovery setup, clock output, data input
        wr(8'h4C, 16'h1); m_dir = 2'b01;
        wr(8'h5C, 16'h3); m_dout = 2'b00;
        ctl_scl_oe = 0; ctl_sda_oe = 0; #1;
        chk("R5 only scl pulled", {pad_sda_oe, pad_scl_oe}, 2'b01);
        wr(8'h58, 16'h1); m_dout = 2'b01; #1;
        chk("R7 scl released", {pad_sda_oe, pad_scl_oe}, 2'b00);
        rd(8'h54, v); chk("R7 sda untouched", v, 16'h1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [15:0] d;
            op = 3'($urandom % 5);
            d  = 16'($urandom);
            ctl_scl_oe = 1'($urandom); ctl_sda_oe = 1'($urandom);
            if (op == 0 && ($urandom % 4) != 0) op = 3'd2;
            case (op)
                3'd0: begin wr(8'h48, d); m_mode = d[0]; end
                3'd1: begin wr(8'h4C, d); m_dir = d[1:0]; end
                3'd2: begin wr(8'h54, d); m_dout = d[1:0]; end
                3'd3: begin wr(8'h58, d); m_dout = m_dout | d[1:0]; end
                default: begin wr(8'h5C, d); m_dout = m_dout & ~d[1:0]; end
            endcase
            #1;
            chk(m_mode ? "R5 gpio oe" : "R2 i2c oe", {14'h0, pad_sda_oe, pad_scl_oe},
                {14'h0, exp_oe(m_mode, m_dir, m_dout, {ctl_sda_oe, ctl_scl_oe})});
            rd(8'h54, v);
            chk(op == 3'd3 ? "R7 set" : op == 3'd4 ? "R8 clear" : "R6 dout", v, {14'h0, m_dout});
            rd(8'h4C, v); chk("R5 dir", v, {14'h0, m_dir});
        end

        // R4 return to I2C
        wr(8'h48, 16'hFFFE); ctl_scl_oe = 1; ctl_sda_oe = 0; #1;
        chk("R4 back to i2c", {pad_sda_oe, pad_scl_oe}, 2'b01);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule